// File: doc/BRIEF.md
# Burst-of-Four Double-Rate SRAM Master

This block is the host-side master for a synchronous SRAM that moves every access as a burst of four words on both clock edges. A host hands it one request at a time over a valid/ready port. Each request carries a burst base address, a read/write flag and, for writes, four data words. The block turns each request into a single load cycle on the memory pins, with an active-low load strobe, a read/write select and the base address. It then drives the write words, or collects the read words, in the two or three cycles that follow.

Double-rate data is modelled as two lanes per clock cycle: a rise lane for the half cycle after the rising edge and a fall lane for the half after the falling edge. Write words leave one full cycle after the load. Read words arrive one and a half cycles after it. The block spaces the load cycles so that bursts on the shared data bus never overlap. A run input tells the block that the memory clocks are running. While it is low, everything holds still.

Top module: `ddrb4_ctrl`

## Requirements
- R1: During and just after reset, the load strobe is high, the bus drive enable is low, the response valid is low, and the host ready is high while run is high.
- R2: A host handshake (req_valid and req_ready high at a rising edge with run high) puts the load strobe low for exactly the next cycle, the load cycle. In that cycle the select is 0 for a write or 1 for a read, and the address pins carry req_addr.
- R3: For a write whose load cycle is t, the drive enable is high in cycles t+1 and t+2 only. Cycle t+1 carries word 0 on the rise lane and word 1 on the fall lane. Cycle t+2 carries word 2 on the rise lane and word 3 on the fall lane. Word k is req_wdata[16k+15:16k] for a 16-bit word width.
- R4: For a read whose load cycle is t, the block takes word 0 from the fall lane of t+1, word 1 from the rise lane of t+2, word 2 from the fall lane of t+2 and word 3 from the rise lane of t+3. It then raises rsp_valid for the single cycle t+4, with word k in rsp_data bits [16k+15:16k].
- R5: Word k of a burst belongs to the memory word whose address is the base address with the two bits k appended below it, where k runs from 0 to 3.
- R6: Host ready is low in every load cycle, so two load cycles are at least two cycles apart. Back-to-back requests that do not follow a read with a write are spaced exactly two cycles apart.
- R7: A write load cycle comes at least three cycles after a read load cycle. Back-to-back read then write requests are spaced exactly three cycles apart.
- R8: The drive enable is never high in a cycle in which read words are due from the memory, that is, cycles t+1 to t+3 of any read.
- R9: While run is low, host ready is low and the load strobe, select, address, drive enable and data lanes hold their values. When run returns, the interrupted burst completes correctly.
- R10: With no host request, the load strobe stays high and no operation starts.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Main clock, rising edge active |
| rst_n | input | 1 | Active-low synchronous reset |
| run | input | 1 | High while the memory clocks are running |
| req_valid | input | 1 | Host request present |
| req_ready | output | 1 | Block can take the request this cycle |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | AW | Burst base address |
| req_wdata | input | 4*DW | Four write words, word 0 in the low bits |
| rsp_valid | output | 1 | One-cycle pulse with a completed read |
| rsp_data | output | 4*DW | Four read words, word 0 in the low bits |
| mem_ld_n | output | 1 | Active-low load strobe |
| mem_rw_n | output | 1 | Select: 0 write, 1 read |
| mem_addr | output | AW | Base address to the memory |
| mem_dq_oe | output | 1 | Drive enable for the shared data bus |
| mem_dq_rise | output | DW | Write word on the rise lane |
| mem_dq_fall | output | DW | Write word on the fall lane |
| mem_q_rise | input | DW | Read word on the rise lane |
| mem_q_fall | input | DW | Read word on the fall lane |

## Verification
The bench builds the block with DW=16 and AW=4, which gives sixteen burst slots. A random mix of reads and writes therefore often reads back a burst that was written a few requests earlier, sometimes while that write is still on the bus. It also hits slots that were never written, which must return zero. The narrow address lets the bench's behavioural memory, which models the write and read latencies and the appended low address bits, check every word position. Directed sequences force the tight read-then-write and read-then-read spacing, and stop the clocks both in the middle of a write burst and while a request waits.

// File: rtl/ddrb4_pkg.sv
package ddrb4_pkg;
   localparam int unsigned DDRB4_BEATS = 4;

   typedef enum logic {
      OP_WRITE = 1'b0,
      OP_READ  = 1'b1
   } ddrb4_op_e;
endpackage

// File: rtl/ddrb4_issue.sv
module ddrb4_issue
   import ddrb4_pkg::*;
#(
   parameter int AW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          accept,
   output logic          ld_n,
   output logic          rw_n,
   output logic [AW-1:0] addr
);
   // cycles since the last load cycle, saturating; 0 marks the load cycle
   logic [1:0] since;
   logic       last_rd;
   ddrb4_op_e  op_next;

   always_comb begin
      op_next   = req_write ? OP_WRITE : OP_READ;
      req_ready = run && (since != 2'd0)
                  && !(last_rd && req_write && (since == 2'd1));
      accept    = req_valid && req_ready;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since   <= 2'd3;
         last_rd <= 1'b0;
         ld_n    <= 1'b1;
         rw_n    <= 1'b1;
         addr    <= '0;
      end else if (run) begin
         ld_n <= !accept;
         if (accept) begin
            since   <= 2'd0;
            last_rd <= (op_next == OP_READ);
            rw_n    <= op_next;
            addr    <= req_addr;
         end else if (since != 2'd3) begin
            since <= since + 2'd1;
         end
      end
   end

   AST_LOAD_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(ld_n) |-> $past(accept)); // R10
   AST_ACCEPT_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
      accept |=> !req_ready); // R6
   AST_RD_WR_GAP: assert property (@(posedge clk) disable iff (!rst_n)
      (run && !ld_n && rw_n) |=> !(req_valid && req_ready && req_write)); // R7
   AST_PINS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(ld_n) && $stable(rw_n) && $stable(addr))); // R9
endmodule

// File: rtl/ddrb4_wrpath.sv
module ddrb4_wrpath
   import ddrb4_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      accept,
   input  logic [DDRB4_BEATS*DW-1:0] wdata,
   input  logic                      ld_n,
   input  logic                      rw_n,
   output logic                      oe,
   output logic [DW-1:0]             rise,
   output logic [DW-1:0]             fall
);
   localparam int BW = DDRB4_BEATS * DW;

   logic [BW-1:0] wbuf;
   logic [DW-1:0] word [DDRB4_BEATS];
   logic          second;

   for (genvar k = 0; k < DDRB4_BEATS; k++) begin : g_word
      assign word[k] = wbuf[k*DW +: DW];
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         wbuf   <= '0;
         second <= 1'b0;
         oe     <= 1'b0;
         rise   <= '0;
         fall   <= '0;
      end else if (run) begin
         if (accept) wbuf <= wdata;
         if (!ld_n && !rw_n) begin
            oe     <= 1'b1;
            rise   <= word[0];
            fall   <= word[1];
            second <= 1'b1;
         end else if (second) begin
            rise   <= word[2];
            fall   <= word[3];
            second <= 1'b0;
         end else begin
            oe <= 1'b0;
         end
      end
   end

   AST_WR_LANES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> ($stable(oe) && $stable(rise) && $stable(fall))); // R9
   AST_WR_TWO_CYCLES: assert property (@(posedge clk) disable iff (!rst_n)
      (run && $rose(oe)) |=> oe); // R3
endmodule

// File: rtl/ddrb4_rdpath.sv
module ddrb4_rdpath
   import ddrb4_pkg::*;
#(
   parameter int DW = 16
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      ld_n,
   input  logic                      rw_n,
   input  logic [DW-1:0]             q_rise,
   input  logic [DW-1:0]             q_fall,
   output logic                      rd_busy,
   output logic                      rsp_valid,
   output logic [DDRB4_BEATS*DW-1:0] rsp_data
);
   logic            st1, st2, st3;
   logic [DW-1:0]   w0;
   logic [3*DW-1:0] w012;

   assign rd_busy = st1 || st2 || st3;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st1       <= 1'b0;
         st2       <= 1'b0;
         st3       <= 1'b0;
         w0        <= '0;
         w012      <= '0;
         rsp_valid <= 1'b0;
         rsp_data  <= '0;
      end else if (run) begin
         st1 <= !ld_n && rw_n;
         st2 <= st1;
         st3 <= st2;
         if (st1) w0 <= q_fall;
         if (st2) w012 <= {q_fall, q_rise, w0};
         if (st3) rsp_data <= {q_rise, w012};
         rsp_valid <= st3;
      end else begin
         rsp_valid <= 1'b0;
      end
   end

   AST_RSP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> !rsp_valid); // R4
endmodule

// File: rtl/ddrb4_ctrl.sv
module ddrb4_ctrl
   import ddrb4_pkg::*;
#(
   parameter int DW = 16,
   parameter int AW = 8
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      run,
   input  logic                      req_valid,
   output logic                      req_ready,
   input  logic                      req_write,
   input  logic [AW-1:0]             req_addr,
   input  logic [DDRB4_BEATS*DW-1:0] req_wdata,
   output logic                      rsp_valid,
   output logic [DDRB4_BEATS*DW-1:0] rsp_data,
   output logic                      mem_ld_n,
   output logic                      mem_rw_n,
   output logic [AW-1:0]             mem_addr,
   output logic                      mem_dq_oe,
   output logic [DW-1:0]             mem_dq_rise,
   output logic [DW-1:0]             mem_dq_fall,
   input  logic [DW-1:0]             mem_q_rise,
   input  logic [DW-1:0]             mem_q_fall
);
   if (DW < 1) begin : g_bad_dw
      $error("ddrb4_ctrl: DW must be at least 1");
   end
   if (AW < 1) begin : g_bad_aw
      $error("ddrb4_ctrl: AW must be at least 1");
   end

   logic accept;
   logic rd_busy;

   ddrb4_issue #(.AW(AW)) u_issue (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .req_valid (req_valid),
      .req_write (req_write),
      .req_addr  (req_addr),
      .req_ready (req_ready),
      .accept    (accept),
      .ld_n      (mem_ld_n),
      .rw_n      (mem_rw_n),
      .addr      (mem_addr)
   );

   ddrb4_wrpath #(.DW(DW)) u_wr (
      .clk    (clk),
      .rst_n  (rst_n),
      .run    (run),
      .accept (accept),
      .wdata  (req_wdata),
      .ld_n   (mem_ld_n),
      .rw_n   (mem_rw_n),
      .oe     (mem_dq_oe),
      .rise   (mem_dq_rise),
      .fall   (mem_dq_fall)
   );

   ddrb4_rdpath #(.DW(DW)) u_rd (
      .clk       (clk),
      .rst_n     (rst_n),
      .run       (run),
      .ld_n      (mem_ld_n),
      .rw_n      (mem_rw_n),
      .q_rise    (mem_q_rise),
      .q_fall    (mem_q_fall),
      .rd_busy   (rd_busy),
      .rsp_valid (rsp_valid),
      .rsp_data  (rsp_data)
   );

   AST_NO_BUS_FIGHT: assert property (@(posedge clk) disable iff (!rst_n)
      !(mem_dq_oe && rd_busy)); // R8
endmodule

// File: tb/test_ddrb4_ctrl.sv
module test_ddrb4_ctrl;
   localparam int DW = 16;
   localparam int AW = 4;
   localparam int BW = 4 * DW;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          run = 1'b1;
   logic          req_valid = 1'b0;
   logic          req_ready;
   logic          req_write = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [BW-1:0] req_wdata = '0;
   logic          rsp_valid;
   logic [BW-1:0] rsp_data;
   logic          mem_ld_n, mem_rw_n, mem_dq_oe;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_dq_rise, mem_dq_fall;
   logic [DW-1:0] mem_q_rise = '0;
   logic [DW-1:0] mem_q_fall = '0;

   always #4 clk = ~clk;

   ddrb4_ctrl #(.DW(DW), .AW(AW)) i_ddrb4_ctrl (
      .clk(clk), .rst_n(rst_n), .run(run),
      .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
      .req_addr(req_addr), .req_wdata(req_wdata),
      .rsp_valid(rsp_valid), .rsp_data(rsp_data),
      .mem_ld_n(mem_ld_n), .mem_rw_n(mem_rw_n), .mem_addr(mem_addr),
      .mem_dq_oe(mem_dq_oe), .mem_dq_rise(mem_dq_rise), .mem_dq_fall(mem_dq_fall),
      .mem_q_rise(mem_q_rise), .mem_q_fall(mem_q_fall)
   );

   int checks = 0;
   int fails  = 0;
   int cyc    = 0;

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // active cycles: only edges with the clocks running count
   always @(posedge clk) if (rst_n && run) cyc <= cyc + 1;

   // behavioural memory: write words one cycle after load, read words 1.5 cycles after
   logic [DW-1:0] tbmem [0:(1<<(AW+2))-1];
   logic [DW-1:0] refm  [0:(1<<(AW+2))-1];
   typedef struct packed { logic v; logic rd; logic [AW-1:0] a; } slot_t;
   slot_t m1, m2;

   initial begin
      for (int i = 0; i < (1 << (AW + 2)); i++) begin
         tbmem[i] = '0;
         refm[i]  = '0;
      end
   end

   always @(posedge clk) begin
      if (!rst_n) begin
         m1 <= '0;
         m2 <= '0;
      end else if (run) begin
         m1 <= '{v: !mem_ld_n, rd: mem_rw_n, a: mem_addr};
         m2 <= m1;
         if (m1.v && !m1.rd) begin
            tbmem[{m1.a, 2'd0}] <= mem_dq_rise;
            tbmem[{m1.a, 2'd1}] <= mem_dq_fall;
         end
         if (m2.v && !m2.rd) begin
            tbmem[{m2.a, 2'd2}] <= mem_dq_rise;
            tbmem[{m2.a, 2'd3}] <= mem_dq_fall;
         end
         if (!mem_ld_n && mem_rw_n) mem_q_fall <= tbmem[{mem_addr, 2'd0}];
         if (m1.v && m1.rd) begin
            mem_q_rise <= tbmem[{m1.a, 2'd1}];
            mem_q_fall <= tbmem[{m1.a, 2'd2}];
         end
         if (m2.v && m2.rd) mem_q_rise <= tbmem[{m2.a, 2'd3}];
      end
   end

   // expectations
   logic [BW-1:0]   exp_q  [$];
   logic [BW-1:0]   expw_q [$];
   logic [AW:0]     expc_q [$];
   int              lat_q  [$];
   logic [BW-1:0]   w_dat;
   int  w_at = -10, rd_at = -10, last_ld = 0, last_gap = 0;
   bit  have_ld = 0, last_rd = 0;

   function automatic logic [BW-1:0] ref_burst(input logic [AW-1:0] a);
      return {refm[{a, 2'd3}], refm[{a, 2'd2}], refm[{a, 2'd1}], refm[{a, 2'd0}]};
   endfunction

   always @(negedge clk) begin
      if (rst_n) begin
         // R3 write words on the lanes, and drive only inside write windows
         if (cyc == w_at + 1)
            chk(mem_dq_oe && mem_dq_rise == w_dat[15:0] && mem_dq_fall == w_dat[31:16], "R3 first cycle",
                {31'd0, mem_dq_oe, mem_dq_fall, mem_dq_rise}, {31'd0, 1'b1, w_dat[31:0]});
         if (cyc == w_at + 2)
            chk(mem_dq_oe && mem_dq_rise == w_dat[47:32] && mem_dq_fall == w_dat[63:48], "R3 second cycle",
                {31'd0, mem_dq_oe, mem_dq_fall, mem_dq_rise}, {31'd0, 1'b1, w_dat[63:32]});
         if (mem_dq_oe && !(cyc == w_at + 1 || cyc == w_at + 2))
            chk(1'b0, "R3 drive outside window", 64'(cyc), 64'(w_at));
         if (mem_dq_oe)
            chk(!(cyc > rd_at && cyc <= rd_at + 3), "R8 bus fight", 64'(cyc), 64'(rd_at));
         // R4 responses
         if (rsp_valid) begin
            if (exp_q.size() == 0 || lat_q.size() == 0) chk(1'b0, "R4 unexpected response", rsp_data, 64'd0);
            else begin
               logic [BW-1:0] e;
               int l;
               e = exp_q.pop_front();
               l = lat_q.pop_front();
               chk(rsp_data == e, "R4 read data", rsp_data, e);
               chk(cyc - l == 4, "R4 latency", 64'(cyc - l), 64'd4);
            end
         end
         // load cycles
         if (run && !mem_ld_n) begin
            if (have_ld) begin
               last_gap = cyc - last_ld;
               if (last_rd && !mem_rw_n) chk(last_gap >= 3, "R7 read-write spacing", 64'(last_gap), 64'd3);
               else chk(last_gap >= 2, "R6 load spacing", 64'(last_gap), 64'd2);
            end
            have_ld = 1;
            last_ld = cyc;
            last_rd = mem_rw_n;
            if (expc_q.size() == 0) chk(1'b0, "R2 load without request", {59'd0, mem_rw_n, mem_addr}, 64'd0);
            else begin
               logic [AW:0] c;
               c = expc_q.pop_front();
               chk({mem_rw_n, mem_addr} == c, "R2 select and address", {59'd0, mem_rw_n, mem_addr}, {59'd0, c});
            end
            if (mem_rw_n) begin
               lat_q.push_back(cyc);
               rd_at = cyc;
            end else begin
               w_at = cyc;
               if (expw_q.size() != 0) w_dat = expw_q.pop_front();
            end
         end
      end
   end

   // host request; called at a falling edge, returns at the falling edge of the load cycle
   task automatic req(input bit wr, input logic [AW-1:0] a, input logic [BW-1:0] d);
      req_valid = 1'b1;
      req_write = wr;
      req_addr  = a;
      req_wdata = d;
      #1;
      while (!req_ready) begin
         @(negedge clk);
         #1;
      end
      expc_q.push_back({!wr, a});
      if (wr) begin
         for (int k = 0; k < 4; k++) refm[{a, 2'(k)}] = d[k*DW +: DW];
         expw_q.push_back(d);
      end else begin
         exp_q.push_back(ref_burst(a));
      end
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic summary;
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      $display("FAIL R2 watchdog: actual timeout expected completion");
      summary();
      $finish;
   end

   initial begin
      logic [AW+2*DW+1:0] snap;
      void'($urandom(32'd20240611));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      #1;
      chk(mem_ld_n && !mem_dq_oe && !rsp_valid && req_ready, "R1 reset state",
          {60'd0, mem_ld_n, mem_dq_oe, rsp_valid, req_ready}, 64'b1001);
      for (int i = 0; i < 5; i++) begin
         @(negedge clk);
         #1;
         chk(mem_ld_n, "R10 idle without request", 64'(mem_ld_n), 64'd1);
      end
      @(negedge clk);

      // R3/R5/R6 directed write
      req(1'b1, 4'd3, 64'h4444_3333_2222_1111);
      #1;
      chk(!req_ready, "R6 ready low in load cycle", 64'(req_ready), 64'd0);
      repeat (3) @(negedge clk);
      for (int k = 0; k < 4; k++)
         chk(tbmem[{4'd3, 2'(k)}] == DW'(16'h1111 * (k + 1)), "R5 word order",
             64'(tbmem[{4'd3, 2'(k)}]), 64'(16'h1111 * (k + 1)));
      req(1'b0, 4'd3, '0);

      // R7 tight read then write, R6 tight read then read
      req(1'b0, 4'd5, '0);
      req(1'b1, 4'd6, 64'hA6A6_0606_B6B6_1616);
      #1;
      chk(last_gap == 3, "R7 back-to-back read then write", 64'(last_gap), 64'd3);
      req(1'b0, 4'd6, '0);
      req(1'b0, 4'd3, '0);
      #1;
      chk(last_gap == 2, "R6 back-to-back reads", 64'(last_gap), 64'd2);
      repeat (6) @(negedge clk);

      // R9 clocks stopped in the middle of a write burst
      req(1'b1, 4'd7, 64'hC7C7_0707_D7D7_1717);
      @(negedge clk);
      #1 run = 1'b0;
      snap = {mem_ld_n, mem_dq_oe, mem_addr, mem_dq_rise, mem_dq_fall};
      for (int i = 0; i < 4; i++) begin
         @(negedge clk);
         #1;
         chk(!req_ready && snap == {mem_ld_n, mem_dq_oe, mem_addr, mem_dq_rise, mem_dq_fall},
             "R9 pins hold while stopped", {27'd0, req_ready, mem_ld_n, mem_dq_oe, mem_addr, mem_dq_rise, mem_dq_fall},
             {28'd0, snap});
      end
      run = 1'b1;
      repeat (3) @(negedge clk);
      // R9 pending request while stopped
      #1 run = 1'b0;
      req_valid = 1'b1; req_write = 1'b1; req_addr = 4'd9;
      for (int i = 0; i < 3; i++) begin
         @(negedge clk);
         #1;
         chk(!req_ready && mem_ld_n, "R9 no load while stopped", {62'd0, req_ready, mem_ld_n}, 64'd1);
      end
      req_valid = 1'b0;
      run = 1'b1;
      @(negedge clk);
      req(1'b0, 4'd7, '0);

      // random mix
      for (int i = 0; i < 300; i++) begin
         bit wr;
         logic [AW-1:0] a;
         wr = 1'($urandom % 2);
         a  = AW'($urandom % 16);
         req(wr, a, {$urandom, $urandom});
         repeat ($urandom % 3) @(negedge clk);
      end
      repeat (12) @(negedge clk);
      chk(exp_q.size() == 0, "R4 all reads answered", 64'(exp_q.size()), 64'd0);
      summary();
      $finish;
   end
endmodule